// File: doc/BRIEF.md
# Three-Wire Synthesizer Configuration Receiver

This block receives configuration words for a frequency synthesizer over a three-line serial bus made of a bit clock, a data line and a frame-enable line. While the enable line is low, each rising edge of the bit clock moves one data bit into the receiver, most significant bit first. When the enable line goes high, the frame is complete. Frames do not all have the same length, so the enable line is the only thing that marks where one ends.

The last two bits of a frame select the target register. The bits before them, aligned to the right, are the value. There are three targets. A settings word includes the mode selection, such as dual-modulus operation. A reference divider takes values such as 800. A combined counter register holds a 14-bit main counter and a 7-bit swallow counter. All three bus lines are asynchronous to the system clock. Each passes through a two-stage synchronizer, and its edges are detected in the system clock domain.

A frame with a valid address and enough bits updates one register and pulses that register's update strobe for one system clock cycle. A frame with the unused address, or with too few bits, changes nothing and pulses an error flag instead.

Top module: `synth_cfg_rx`

## Requirements
- R1: After reset, all four register outputs are zero and no strobe or error flag is high.
- R2: A data bit is captured only on a rising edge of the bit clock while enable is low. Bit-clock edges while enable is high have no effect on the next frame or on any output.
- R3: A rising edge of enable ends the frame. The two last-received bits form the address, with the second-to-last bit as the upper bit: 00 selects settings, 10 selects the reference divider, 01 selects the counter register, and 11 is invalid.
- R4: A settings frame needs at least 16 bits. The 14 bits before the address are loaded into the settings output.
- R5: A reference frame needs at least 18 bits. The 16 bits before the address are loaded into the reference divider output.
- R6: A counter frame needs at least 23 bits. Of the 21 bits before the address, the upper 14 form the main counter and the lower 7 form the swallow counter.
- R7: For frames longer than needed, only the most recent bits count. The receiver keeps the last 24 bits, and older bits are dropped.
- R8: A frame with address 11, or with fewer bits than its register needs (a frame of fewer than two bits included), pulses the error flag and leaves every register unchanged.
- R9: The update strobe or the error flag goes high for exactly one cycle, three system clocks after enable goes high at the input. At most one of them is high in any cycle.
- R10: A register output keeps its value until a valid frame addressed to it arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_en | input | 1 | Frame enable; low during a frame, rising edge ends it |
| settings_o | output | 14 | Settings register |
| ref_div_o | output | 16 | Reference divider register |
| main_cnt_o | output | 14 | Main counter |
| swallow_cnt_o | output | 7 | Swallow counter |
| set_upd_o | output | 1 | One-cycle pulse on a settings update |
| ref_upd_o | output | 1 | One-cycle pulse on a reference divider update |
| cnt_upd_o | output | 1 | One-cycle pulse on a counter update |
| frame_err_o | output | 1 | One-cycle pulse on a rejected frame |

## Verification
The bench sends frames one bit shorter than each register needs. A receiver with an off-by-one length check would accept these and write shifted values. It sends a 24-bit counter frame and a 28-bit settings frame, which expose a receiver that fails to drop the oldest bits or that misaligns the payload. Bit-clock pulses sent while enable is high, and a frame with no bits at all, catch a design that shifts outside a frame or decodes a stale address. Because the strobes are compared on every cycle, a strobe that is one cycle late, lasts two cycles, or fires together with the error flag is reported.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        TGT_SETTINGS = 2'b00,
        TGT_COUNTERS = 2'b01,
        TGT_REFDIV   = 2'b10,
        TGT_INVALID  = 2'b11
    } cfg_target_e;
endpackage

// File: rtl/synth_cfg_sync.sv
module synth_cfg_sync #(
    parameter int               LINES   = 3,
    parameter int               STAGES  = 2,
    parameter logic [LINES-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LINES-1:0] din,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise
);
    localparam int PIPE_W = STAGES + 1;

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [PIPE_W-1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[PIPE_W-2:0], din[l]};
        end

        always_ff @(posedge clk) begin
            if (rst) pipe_q <= {PIPE_W{RST_VAL[l]}};
            else     pipe_q <= pipe_d;
        end

        assign level[l] = pipe_q[STAGES-1];
        assign rise[l]  = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end
endmodule

// File: rtl/synth_cfg_shift.sv
module synth_cfg_shift #(
    parameter int SR_W  = 24,
    parameter int CNT_W = $clog2(SR_W + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_stb,
    input  logic             bit_val,
    input  logic             frame_end,
    output logic [SR_W-1:0]  sr_o,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SR_W);

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic [CNT_W-1:0] cnt;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_end) begin
            st_d.cnt = '0;
        end else if (bit_stb) begin
            st_d.sr = {st_q.sr[SR_W-2:0], bit_val};
            if (st_q.cnt != CNT_MAX) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sr_o  = st_q.sr;
    assign cnt_o = st_q.cnt;

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= CNT_MAX); // R7
    AST_CNT_CLEARED: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> (st_q.cnt == '0)); // R3
endmodule

// File: rtl/synth_cfg_decode.sv
module synth_cfg_decode
    import synth_cfg_pkg::*;
#(
    parameter int SR_W  = 24,
    parameter int CNT_W = $clog2(SR_W + 1),
    parameter int SET_W = 14,
    parameter int REF_W = 16,
    parameter int N_W   = 14,
    parameter int A_W   = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_end,
    input  logic [SR_W-1:0]  sr,
    input  logic [CNT_W-1:0] cnt,
    output logic [SET_W-1:0] set_o,
    output logic [REF_W-1:0] ref_o,
    output logic [N_W-1:0]   n_o,
    output logic [A_W-1:0]   a_o,
    output logic             upd_set_o,
    output logic             upd_ref_o,
    output logic             upd_cnt_o,
    output logic             err_o
);
    localparam int PAY_W = SR_W - ADDR_W;
    localparam logic [CNT_W-1:0] SET_LEN = CNT_W'(SET_W + ADDR_W);
    localparam logic [CNT_W-1:0] REF_LEN = CNT_W'(REF_W + ADDR_W);
    localparam logic [CNT_W-1:0] CTR_LEN = CNT_W'(N_W + A_W + ADDR_W);
    localparam logic [CNT_W-1:0] MIN_LEN = CNT_W'(ADDR_W);

    typedef struct packed {
        logic [SET_W-1:0] set;
        logic [REF_W-1:0] refd;
        logic [N_W-1:0]   n;
        logic [A_W-1:0]   a;
        logic             upd_set;
        logic             upd_ref;
        logic             upd_cnt;
        logic             err;
    } dec_st_t;

    dec_st_t     st_d, st_q;
    logic [PAY_W-1:0] payload;
    cfg_target_e target;

    assign payload = sr[SR_W-1:ADDR_W];
    assign target  = cfg_target_e'(sr[ADDR_W-1:0]);

    always_comb begin
        st_d         = st_q;
        st_d.upd_set = 1'b0;
        st_d.upd_ref = 1'b0;
        st_d.upd_cnt = 1'b0;
        st_d.err     = 1'b0;
        if (frame_end) begin
            if (cnt < MIN_LEN) begin
                st_d.err = 1'b1;
            end else begin
                unique case (target)
                    TGT_SETTINGS: begin
                        if (cnt >= SET_LEN) begin
                            st_d.set     = payload[SET_W-1:0];
                            st_d.upd_set = 1'b1;
                        end else st_d.err = 1'b1;
                    end
                    TGT_REFDIV: begin
                        if (cnt >= REF_LEN) begin
                            st_d.refd    = payload[REF_W-1:0];
                            st_d.upd_ref = 1'b1;
                        end else st_d.err = 1'b1;
                    end
                    TGT_COUNTERS: begin
                        if (cnt >= CTR_LEN) begin
                            st_d.n       = payload[A_W +: N_W];
                            st_d.a       = payload[A_W-1:0];
                            st_d.upd_cnt = 1'b1;
                        end else st_d.err = 1'b1;
                    end
                    default: st_d.err = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign set_o     = st_q.set;
    assign ref_o     = st_q.refd;
    assign n_o       = st_q.n;
    assign a_o       = st_q.a;
    assign upd_set_o = st_q.upd_set;
    assign upd_ref_o = st_q.upd_ref;
    assign upd_cnt_o = st_q.upd_cnt;
    assign err_o     = st_q.err;

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({st_q.upd_set, st_q.upd_ref, st_q.upd_cnt, st_q.err})); // R9
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (st_q.upd_set || st_q.upd_ref || st_q.upd_cnt || st_q.err) |=>
        !(st_q.upd_set || st_q.upd_ref || st_q.upd_cnt || st_q.err)); // R9
    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        st_q.err |-> ($stable(st_q.set) && $stable(st_q.refd)
                      && $stable(st_q.n) && $stable(st_q.a))); // R8
    AST_SET_HOLD: assert property (@(posedge clk) disable iff (rst)
        !st_q.upd_set |-> $stable(st_q.set)); // R10
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !st_q.upd_cnt |-> ($stable(st_q.n) && $stable(st_q.a))); // R10
endmodule

// File: rtl/synth_cfg_rx.sv
module synth_cfg_rx #(
    parameter int SYNC_STAGES = 2,
    parameter int SR_W        = 24,
    parameter int SET_W       = 14,
    parameter int REF_W       = 16,
    parameter int N_W         = 14,
    parameter int A_W         = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_en,
    output logic [SET_W-1:0] settings_o,
    output logic [REF_W-1:0] ref_div_o,
    output logic [N_W-1:0]   main_cnt_o,
    output logic [A_W-1:0]   swallow_cnt_o,
    output logic             set_upd_o,
    output logic             ref_upd_o,
    output logic             cnt_upd_o,
    output logic             frame_err_o
);
    localparam int CNT_W   = $clog2(SR_W + 1);
    localparam int L_CLK   = 0;
    localparam int L_DAT   = 1;
    localparam int L_EN    = 2;

    logic [2:0]       lvl, rise;
    logic             bit_stb, frame_end;
    logic [SR_W-1:0]  sr;
    logic [CNT_W-1:0] cnt;

    synth_cfg_sync #(
        .LINES   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({ser_en, ser_dat, ser_clk}),
        .level (lvl),
        .rise  (rise)
    );

    assign bit_stb   = rise[L_CLK] & ~lvl[L_EN];
    assign frame_end = rise[L_EN];

    synth_cfg_shift #(.SR_W(SR_W), .CNT_W(CNT_W)) u_shift (
        .clk       (clk),
        .rst       (rst),
        .bit_stb   (bit_stb),
        .bit_val   (lvl[L_DAT]),
        .frame_end (frame_end),
        .sr_o      (sr),
        .cnt_o     (cnt)
    );

    synth_cfg_decode #(
        .SR_W (SR_W), .CNT_W (CNT_W), .SET_W (SET_W),
        .REF_W(REF_W), .N_W (N_W), .A_W (A_W)
    ) u_decode (
        .clk       (clk),
        .rst       (rst),
        .frame_end (frame_end),
        .sr        (sr),
        .cnt       (cnt),
        .set_o     (settings_o),
        .ref_o     (ref_div_o),
        .n_o       (main_cnt_o),
        .a_o       (swallow_cnt_o),
        .upd_set_o (set_upd_o),
        .upd_ref_o (ref_upd_o),
        .upd_cnt_o (cnt_upd_o),
        .err_o     (frame_err_o)
    );

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (lvl[L_EN] && !frame_end) |=> $stable(cnt)); // R2
    AST_EVENT_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> !(set_upd_o || ref_upd_o || cnt_upd_o || frame_err_o)); // R9
endmodule

// File: tb/synth_cfg_rx_bench.sv
`timescale 1ns/1ps
module synth_cfg_rx_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b1;
    logic [13:0] settings_o;
    logic [15:0] ref_div_o;
    logic [13:0] main_cnt_o;
    logic [6:0]  swallow_cnt_o;
    logic set_upd_o, ref_upd_o, cnt_upd_o, frame_err_o;

    always #4 clk = ~clk; // 125 MHz

    synth_cfg_rx u_synth_cfg_rx (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .settings_o(settings_o), .ref_div_o(ref_div_o), .main_cnt_o(main_cnt_o),
        .swallow_cnt_o(swallow_cnt_o), .set_upd_o(set_upd_o), .ref_upd_o(ref_upd_o),
        .cnt_upd_o(cnt_upd_o), .frame_err_o(frame_err_o)
    );

    int errors = 0, checks = 0;
    bit done = 0;
    string cur_req = "R1";

    // reference model state
    bit  bits_q[$];
    longint exp_set = 0, exp_ref = 0, exp_n = 0, exp_a = 0;
    int  cd = 0;            // cycles until the pending result shows at the ports
    int  pend_kind = 0;     // 0 settings, 1 reference, 2 counters, 3 error
    longint pend_pay = 0;
    bit  e_set, e_ref, e_cnt, e_err;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic send_bit(input bit b);
        ser_dat = b;
        tick(3);
        ser_clk = 1'b1;
        if (ser_en == 1'b0) bits_q.push_back(b); // R2: only while enable low
        tick(3);
        ser_clk = 1'b0;
        tick(1);
    endtask

    // model of the decoding rules (R3..R8)
    task automatic end_frame();
        int n;
        longint pay;
        bit [1:0] adr;
        n = bits_q.size();
        pay = 0;
        for (int i = 0; i < n - 2; i++) pay = (pay << 1) | longint'(bits_q[i]);
        pay = pay & 64'h3F_FFFF; // only the last 24 bits survive (R7)
        if (n < 2) pend_kind = 3;
        else begin
            adr = {bits_q[n-2], bits_q[n-1]};
            case (adr)
                2'b00: pend_kind = (n >= 16) ? 0 : 3;
                2'b10: pend_kind = (n >= 18) ? 1 : 3;
                2'b01: pend_kind = (n >= 23) ? 2 : 3;
                default: pend_kind = 3;
            endcase
        end
        pend_pay = pay;
        ser_en = 1'b1;
        cd = 4;
        tick(8);
    endtask

    task automatic send_frame(input logic [31:0] val, input int nbits);
        ser_en = 1'b0;
        bits_q.delete();
        tick(3);
        for (int i = nbits - 1; i >= 0; i--) send_bit(val[i]);
        end_frame();
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !done) begin
            e_set = 0; e_ref = 0; e_cnt = 0; e_err = 0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    case (pend_kind)
                        0: begin exp_set = pend_pay & 14'h3FFF; e_set = 1; end
                        1: begin exp_ref = pend_pay & 16'hFFFF; e_ref = 1; end
                        2: begin exp_n = (pend_pay >> 7) & 14'h3FFF;
                                 exp_a = pend_pay & 7'h7F; e_cnt = 1; end
                        default: e_err = 1;
                    endcase
                end
            end
            chk(settings_o == exp_set[13:0] && ref_div_o == exp_ref[15:0]
                && main_cnt_o == exp_n[13:0] && swallow_cnt_o == exp_a[6:0],
                cur_req,
                {settings_o, ref_div_o, main_cnt_o, swallow_cnt_o},
                {exp_set[13:0], exp_ref[15:0], exp_n[13:0], exp_a[6:0]});
            chk({set_upd_o, ref_upd_o, cnt_upd_o, frame_err_o} == {e_set, e_ref, e_cnt, e_err},
                "R9 strobe", {set_upd_o, ref_upd_o, cnt_upd_o, frame_err_o},
                {e_set, e_ref, e_cnt, e_err});
        end
    end

    initial begin
        #1600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst = 1'b0;
        cur_req = "R1";               // reset state, compared each cycle
        tick(5);
        cur_req = "R4";               // settings frame, 16 bits, address 00
        send_frame({14'h1A53, 2'b00}, 16);
        cur_req = "R5";               // reference divider 800, address 10
        send_frame({16'd800, 2'b10}, 18);
        cur_req = "R6";               // main 2495, swallow 60, address 01
        send_frame({14'd2495, 7'd60, 2'b01}, 23);
        cur_req = "R2";               // clock pulses with enable high are ignored
        for (int k = 0; k < 5; k++) send_bit(1'b1);
        tick(4);
        send_frame({14'h0421, 2'b00}, 16);
        cur_req = "R8";               // counter frame one bit short
        send_frame({14'd77, 6'd5, 2'b01}, 22);
        cur_req = "R8";               // invalid address 11
        send_frame({14'h3FFF, 2'b11}, 16);
        cur_req = "R8";               // reference frame one bit short
        send_frame({15'd999, 2'b10}, 17);
        cur_req = "R8";               // empty frame
        send_frame(32'h0, 0);
        cur_req = "R8";               // single-bit frame
        send_frame(32'h1, 1);
        cur_req = "R7";               // 24-bit counter frame, oldest bit dropped
        send_frame({1'b1, 14'd1234, 7'd99, 2'b01}, 24);
        cur_req = "R7";               // 28-bit settings frame
        send_frame({14'h2AAA, 14'h1555, 2'b00}, 28);
        cur_req = "R3";               // back-to-back addresses, min lengths
        send_frame({16'hBEEF, 2'b10}, 18);
        send_frame({14'h3FFF, 7'h7F, 2'b01}, 23);
        cur_req = "R10";              // values persist while idle
        tick(20);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule